// File: doc/BRIEF.md
# Masked-Write Module Reset Controller

This block drives the reset lines of a set of on-chip modules from a small register bus. The lines are grouped sixteen to a control word. Every write carries its own per-bit enable mask in the upper half of the data. A single line can therefore be asserted or released without first reading the word back, and the other lines in that word are not disturbed.

Each control word has a matching monitor word. A monitor bit reads 1 while its line is held in reset and 0 once the line is free. A monitor bit does not move when its control bit changes. It moves only after a fixed, parameterised number of clock cycles, which models the time the reset takes to propagate through the target module. Software writes the control word and then polls the monitor word until it shows the new state.

Top module: `mrc_top`

## Requirements
- R1: Control word n is at byte address 0x900 + 4·n and monitor word n is at 0xA00 + 4·n, for n below NUM_WORDS. Any other address, including one that is not word aligned, reads as 0, and a write to it changes nothing.
- R2: In a write to a control word, data bit 16+b is the write enable for control bit b (b = 0..15). A control bit whose enable is 0 keeps its value.
- R3: A control bit whose enable is 1 takes data bit b. The value 0 asserts that reset and the value 1 releases it. Output modRstN[16·n+b] equals control bit b of word n, so it is low while the reset is asserted.
- R4: A read of a control word returns the control bits in 15:0. A read of a monitor word returns the monitor bits in 15:0. In both cases bits 31:16 read as 0.
- R5: After rstN, every control bit is 0 (asserted) and every monitor bit is 1.
- R6: A monitor bit settles to the inverse of its control bit exactly SETTLE_CYCLES rising clock edges after the edge that changed the control bit. It keeps its old value at every edge before that.
- R7: If a control bit returns to its earlier value before its settle time has run out, its monitor bit does not change. A later change starts the full count again.
- R8: A write to a monitor word changes no control bit and no monitor bit.
- R9: A write to a control word with all sixteen enables at 0 leaves the whole word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address of the register access |
| busWdata | input | 32 | Write data: enables in 31:16, values in 15:0 |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busRdata | output | 32 | Read data for busAddr, combinational |
| modRstN | output | NUM_WORDS·16 | Reset lines to the modules, low while asserted |

## Verification
The bench releases and then re-asserts every line in turn. After each change it reads the monitor at every cycle of the settle window. A monitor that moved one edge early or one edge late, or that copied the control bit without inverting it, would show up at a known cycle. Many writes with mixed enable masks are sent to both words and compared with a bench model. A design that merged the data with the old value, or that ignored the enables, would lose its untouched bits here. The bench also toggles a line and puts it back before it settles, and probes out-of-range, unaligned and monitor addresses. A design without a count restart, or one that decoded those addresses loosely, would show a spurious monitor flip or a changed word.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  localparam int LINES_PER_WORD = 16;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 2 * LINES_PER_WORD;

  typedef struct packed {
    logic       wrCtrl;
    logic       rdCtrl;
    logic       rdMon;
    logic [7:0] wordSel;
  } strobe_t;
endpackage

// File: rtl/mrc_decode.sv
module mrc_decode #(
  parameter int NUM_WORDS = 2
) (
  input  logic [mrc_pkg::ADDR_W-1:0] busAddr,
  input  logic                       busWrite,
  output mrc_pkg::strobe_t           strobe
);
  logic [5:0] wordIdx;
  logic       inRange;

  assign wordIdx = busAddr[7:2];
  assign inRange = (busAddr[1:0] == 2'b00) && (int'(wordIdx) < NUM_WORDS);

  always_comb begin
    strobe = '0;
    strobe.wordSel = {2'b00, wordIdx};
    case (busAddr[11:8])
      4'h9: begin
        strobe.rdCtrl = inRange;
        strobe.wrCtrl = inRange && busWrite;
      end
      4'hA: strobe.rdMon = inRange;
      default: ;
    endcase
  end
endmodule

// File: rtl/mrc_settle.sv
module mrc_settle #(
  parameter int SETTLE_CYCLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic ctrlBit,
  output logic monBit
);
  localparam int CNT_W = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic             ctrlSeen;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curCnt;

  assign curCnt = (ctrlBit != ctrlSeen) ? '0 : cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlSeen <= 1'b0;
      cnt      <= '0;
      monBit   <= 1'b1;
    end else begin
      ctrlSeen <= ctrlBit;
      if (monBit == ctrlBit) begin
        if (curCnt == LAST) begin
          monBit <= ~ctrlBit;
          cnt    <= '0;
        end else begin
          cnt <= curCnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/mrc_bank.sv
module mrc_bank #(
  parameter int NUM_WORDS     = 2,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  mrc_pkg::strobe_t                          strobe,
  input  logic [mrc_pkg::DATA_W-1:0]                wrData,
  output logic [mrc_pkg::DATA_W-1:0]                rdData,
  output logic [NUM_WORDS*mrc_pkg::LINES_PER_WORD-1:0] ctrlVec,
  output logic [NUM_WORDS*mrc_pkg::LINES_PER_WORD-1:0] monVec
);
  localparam int LINES = mrc_pkg::LINES_PER_WORD;
  localparam int TOTAL = NUM_WORDS * LINES;

  logic [LINES-1:0] wrEn;
  logic [LINES-1:0] wrVal;

  assign wrEn  = wrData[2*LINES-1:LINES];
  assign wrVal = wrData[LINES-1:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    logic [LINES-1:0] ctrlQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctrlQ <= '0;
      end else if (strobe.wrCtrl && strobe.wordSel == 8'(w)) begin
        ctrlQ <= (ctrlQ & ~wrEn) | (wrVal & wrEn);
      end
    end
    assign ctrlVec[w*LINES +: LINES] = ctrlQ;
  end

  for (genvar i = 0; i < TOTAL; i++) begin : gLine
    mrc_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) uSettle (
      .clk    (clk),
      .rstN   (rstN),
      .ctrlBit(ctrlVec[i]),
      .monBit (monVec[i])
    );
  end

  always_comb begin
    rdData = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (strobe.wordSel == 8'(w)) begin
        if (strobe.rdCtrl) rdData[LINES-1:0] = ctrlVec[w*LINES +: LINES];
        if (strobe.rdMon)  rdData[LINES-1:0] = monVec[w*LINES +: LINES];
      end
    end
  end
endmodule

// File: rtl/mrc_top.sv
module mrc_top #(
  parameter int NUM_WORDS     = 2,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [11:0]                   busAddr,
  input  logic [31:0]                   busWdata,
  input  logic                          busWrite,
  output logic [31:0]                   busRdata,
  output logic [NUM_WORDS*16-1:0]       modRstN
);
  mrc_pkg::strobe_t        strobe;
  logic [NUM_WORDS*16-1:0] monVec;

  mrc_decode #(.NUM_WORDS(NUM_WORDS)) uDecode (
    .busAddr (busAddr),
    .busWrite(busWrite),
    .strobe  (strobe)
  );

  mrc_bank #(.NUM_WORDS(NUM_WORDS), .SETTLE_CYCLES(SETTLE_CYCLES)) uBank (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (busWdata),
    .rdData (busRdata),
    .ctrlVec(modRstN),
    .monVec (monVec)
  );
endmodule

// File: rtl/mrc_checker.sv
module mrc_checker #(
  parameter int NUM_WORDS = 2
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [11:0]             busAddr,
  input logic [31:0]             busWdata,
  input logic                    busWrite,
  input logic [31:0]             busRdata,
  input logic [NUM_WORDS*16-1:0] modRstN,
  input logic [NUM_WORDS*16-1:0] monVec
);
  logic ctrlWord0Wr;
  assign ctrlWord0Wr = busWrite && (busAddr == 12'h900);

  // R2: bits without an enable keep their value
  a_r2_masked_hold: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord0Wr |=> (((modRstN[15:0] ^ $past(modRstN[15:0])) & ~$past(busWdata[31:16])) == 16'h0));

  // R3: enabled bits take the written value
  a_r3_enabled_take: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWord0Wr |=> ((modRstN[15:0] & $past(busWdata[31:16])) ==
                     ($past(busWdata[15:0]) & $past(busWdata[31:16]))));

  // R8: without a control write no line moves
  a_r8_lines_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && busAddr[11:8] == 4'h9) |=> $stable(modRstN));

  // R4: upper half of any read is zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    busRdata[31:16] == 16'h0);

  // R6: a monitor bit only moves to the inverse of its control bit
  a_r6_mon_toward: assert property (@(posedge clk) disable iff (!rstN)
    (monVec != $past(monVec)) |->
      (((monVec ^ $past(monVec)) & (monVec ^ ~$past(modRstN))) == '0));
endmodule

bind mrc_top mrc_checker #(.NUM_WORDS(NUM_WORDS)) uChecker (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .busWrite(busWrite),
  .busRdata(busRdata),
  .modRstN (modRstN),
  .monVec  (monVec)
);

// File: tb/mrc_top_test.sv
module mrc_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 2;
  localparam int SC = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [11:0]       busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic              busWrite = 1'b0;
  logic [31:0]       busRdata;
  logic [NW*16-1:0]  modRstN;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  logic [15:0] ctrlM [NW];
  logic [15:0] monM  [NW];
  logic [31:0] seed = 32'h1234_5679;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrc_top #(.NUM_WORDS(NW), .SETTLE_CYCLES(SC)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWrite(busWrite), .busRdata(busRdata), .modRstN(modRstN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  function automatic logic [11:0] ctrlAddr(input int w);
    return 12'(12'h900 + 4 * w);
  endfunction
  function automatic logic [11:0] monAddr(input int w);
    return 12'(12'hA00 + 4 * w);
  endfunction

  task automatic modelWr(input int w, input logic [31:0] d);
    ctrlM[w] = (ctrlM[w] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic checkAllState(input string tag);
    logic [31:0] r;
    for (int w = 0; w < NW; w++) begin
      busRd(ctrlAddr(w), r);
      check({tag, " ctrl"}, r, {16'h0, ctrlM[w]});
      busRd(monAddr(w), r);
      check({tag, " mon"}, r, {16'h0, monM[w]});
      check({tag, " lines"}, 32'(modRstN[w*16 +: 16]), {16'h0, ctrlM[w]});
    end
  endtask

  // R6: monitor must hold old value for SC-1 edges, then settle at edge SC
  task automatic settleWindow(input int w, input int b);
    logic [31:0] r;
    for (int k = 1; k <= SC; k++) begin
      @(negedge clk);
      if (k == SC) monM[w][b] = ~ctrlM[w][b];
      busRd(monAddr(w), r);
      check("R6 settle timing", r, {16'h0, monM[w]});
    end
  endtask

  initial begin
    logic [31:0] r;
    for (int w = 0; w < NW; w++) begin ctrlM[w] = '0; monM[w] = '1; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkAllState("R5 reset");

    // R3/R6: every line released then asserted, window checked
    for (int w = 0; w < NW; w++) begin
      for (int b = 0; b < 16; b++) begin
        busWr(ctrlAddr(w), (32'h1 << (16 + b)) | (32'h1 << b));
        modelWr(w, (32'h1 << (16 + b)) | (32'h1 << b));
        check("R3 release line", 32'(modRstN[w*16 + b]), 32'h1);
        settleWindow(w, b);
        busWr(ctrlAddr(w), 32'h1 << (16 + b));
        modelWr(w, 32'h1 << (16 + b));
        check("R3 assert line", 32'(modRstN[w*16 + b]), 32'h0);
        settleWindow(w, b);
      end
    end
    checkAllState("R3 sweep end");

    // R2/R4: mixed masks
    for (int n = 0; n < 300; n++) begin
      int w;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      w = int'(seed[31]);
      busWr(ctrlAddr(w), seed);
      modelWr(w, seed);
      busRd(ctrlAddr(w), r);
      check("R2 masked write", r, {16'h0, ctrlM[w]});
      check("R2 lines", 32'(modRstN[w*16 +: 16]), {16'h0, ctrlM[w]});
      repeat (SC) @(negedge clk);
      for (int v = 0; v < NW; v++) monM[v] = ~ctrlM[v];
      busRd(monAddr(w), r);
      check("R6 settled", r, {16'h0, monM[w]});
    end

    // R9: no enables
    busWr(ctrlAddr(0), 32'h0000_FFFF);
    busWr(ctrlAddr(1), 32'h0000_0000);
    repeat (SC + 2) @(negedge clk);
    checkAllState("R9 empty mask");

    // R8: monitor writes ignored
    busWr(monAddr(0), 32'hFFFF_FFFF);
    busWr(monAddr(1), 32'hFFFF_0000);
    repeat (SC + 2) @(negedge clk);
    checkAllState("R8 monitor write");

    // R1: out-of-range and unaligned addresses
    busWr(ctrlAddr(NW), 32'hFFFF_AAAA);
    busWr(12'h901, 32'hFFFF_5555);
    busWr(12'h800, 32'hFFFF_5555);
    repeat (SC + 2) @(negedge clk);
    checkAllState("R1 unmapped write");
    busRd(ctrlAddr(NW), r); check("R1 unmapped read", r, 32'h0);
    busRd(12'h902, r);      check("R1 unaligned read", r, 32'h0);
    busRd(monAddr(NW), r);  check("R1 unmapped mon read", r, 32'h0);

    // R7: toggle and restore before settle
    busWr(ctrlAddr(0), 32'h0001_0000);
    busWr(ctrlAddr(0), 32'h0001_0001);
    busWr(ctrlAddr(0), 32'h0001_0000);
    ctrlM[0][0] = 1'b0; monM[0][0] = 1'b1;
    for (int k = 0; k < 2 * SC; k++) begin
      @(negedge clk);
      busRd(monAddr(0), r);
      check("R7 no flip", r, {16'h0, monM[0]});
    end
    // R7: change after restart takes the full window
    busWr(ctrlAddr(0), 32'h0001_0001);
    ctrlM[0][0] = 1'b1;
    settleWindow(0, 0);

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule